// File: doc/BRIEF.md
# Beam-Synchronous Slice Gate

This block sits in the path of a stream of time slices, each tagged with four beam timing flags, and decides which slices go on to storage. It keeps three running counters: a position within the proton revolution, a position within the antiproton revolution, and a turn number. The beam markers on the flags re-phase these counters, and every forwarded slice carries their values. Two per-position mask vectors can thin the stream to chosen sample positions. A link enable mask clears the data lanes of links that are switched off. An optional capture window limits forwarding to a programmed number of turns. The window opens on an injection flag or on a software start command.

Configuration arrives over a write-only register bus that takes one word per cycle. Slices enter and leave on valid/ready handshakes with a single output register. A slice is taken when `in_valid` and `in_ready` are both high on a clock edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-pressure from `out_ready` reaches the input at once. A taken slice that the gate rejects is dropped and produces no output beat. The counters advance once per taken slice, whether or not that slice is forwarded.

Top module: `turn_sample_filter`

## Requirements
- R1: Every taken slice receives a proton position label. The label is 0 if flag bit 1 (proton marker) is set. Otherwise it is the previous label plus one, wrapping from SAMPLES-1 (317) to 0. The first slice after reset is labelled 0.
- R2: The antiproton position label follows the same rule as R1, driven by flag bit 0 (antiproton marker).
- R3: The turn label is 16 bits wide. It is 0 when flag bit 3 or bit 2 (an injection) is set. Otherwise it holds the previous turn label, plus one if the previous slice carried proton label 317.
- R4: A proton marker that arrives on the slice whose label would otherwise be 317 forces that label to 0, and the turn does not advance after it.
- R5: With filtering on (register 0x00 bit 0), a slice is forwarded only when proton mask bit [proton label] or antiproton mask bit [antiproton label] is set. Mask bit b is stored in bit b%32 of register 0x10+b/32 (proton) or 0x20+b/32 (antiproton). All mask bits reset to 0.
- R6: With filtering off, every slice is forwarded, subject only to the capture window.
- R7: Link i owns data bits [i*LANE_W +: LANE_W]. Its lane is output as zero when bit i of register 0x01 is clear. That register resets to all ones.
- R8: With window mode on (register 0x00 bit 1) and no window open, an injection slice opens a window that includes that slice, provided the done flag is clear. The window closes after the slice that completes the N-th proton turn (N in register 0x02), and `acq_done` is then raised. While done is set, injections are ignored.
- R9: Writing 1 to bit 0 of register 0x03 clears `acq_done` and opens a window starting with the next taken slice. If N is 0, the write sets `acq_done` instead and captures nothing.
- R10: With window mode off, the window has no effect and `acq_active`/`acq_done` do not gate forwarding.
- R11: `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, the output beat holds steady. After reset, `out_valid`, `acq_active` and `acq_done` are low.
- R12: Each output beat carries the proton, antiproton and turn labels of the slice it came from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register word address |
| wr_data | input | 32 | Register write data |
| in_valid | input | 1 | Input slice valid |
| in_ready | output | 1 | Input slice ready |
| in_flags | input | 4 | Timing flags: 3 proton injection, 2 antiproton injection, 1 proton marker, 0 antiproton marker |
| in_data | input | NLINK*LANE_W | Slice data, one lane per link |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat ready |
| out_data | output | NLINK*LANE_W | Forwarded data with disabled lanes cleared |
| out_psamp | output | $clog2(SAMPLES) | Proton position label |
| out_asamp | output | $clog2(SAMPLES) | Antiproton position label |
| out_turn | output | TURN_W | Turn label |
| acq_active | output | 1 | Capture window open |
| acq_done | output | 1 | Capture of N turns completed |

## Verification
Two events can coincide on the same slice: a position counter's natural wrap from 317, and a marker that re-phases that counter. In the same way, a window can close at the turn end of the same slice that is judged by the masks. The bench provokes the first collision directly. It sends a proton marker, then exactly 316 plain slices, then a second marker, so the label is forced to 0 where it would have been 317. It then expects the turn not to advance. Window closure is checked across multi-turn captures. Each output beat and the done/active flags are compared against an independent slice-by-slice model, under random output stalls.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  // register word addresses
  localparam int ADDR_CTRL   = 'h00;  // bit0 filter on, bit1 window mode
  localparam int ADDR_LINKEN = 'h01;
  localparam int ADDR_NTURNS = 'h02;
  localparam int ADDR_CMD    = 'h03;  // bit0 start
  localparam int PMASK_BASE  = 'h10;
  localparam int AMASK_BASE  = 'h20;
  // flag bit positions on the slice
  localparam int FL_PINJ  = 3;
  localparam int FL_AINJ  = 2;
  localparam int FL_PMARK = 1;
  localparam int FL_AMARK = 0;
endpackage

// File: rtl/tsf_regs.sv
module tsf_regs #(
  parameter int NLINK   = 8,
  parameter int SAMPLES = 318,
  parameter int TURN_W  = 16,
  parameter int ADDR_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [31:0]         wr_data,
  output logic                filter_en,
  output logic                window_en,
  output logic [TURN_W-1:0]   nturns,
  output logic [NLINK-1:0]    link_en,
  output logic [SAMPLES-1:0]  pmask,
  output logic [SAMPLES-1:0]  amask,
  output logic                start
);
  import tsf_pkg::*;

  assign start = wr_en && (wr_addr == ADDR_W'(ADDR_CMD)) && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filter_en <= 1'b0;
      window_en <= 1'b0;
      nturns    <= '0;
      link_en   <= '1;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(ADDR_CTRL)) begin
        filter_en <= wr_data[0];
        window_en <= wr_data[1];
      end
      if (wr_addr == ADDR_W'(ADDR_LINKEN)) link_en <= wr_data[NLINK-1:0];
      if (wr_addr == ADDR_W'(ADDR_NTURNS)) nturns <= wr_data[TURN_W-1:0];
    end
  end

  // mask bit b lives in word b/32, lane b%32
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pmask <= '0;
      amask <= '0;
    end else begin
      for (int b = 0; b < SAMPLES; b++) begin
        if (wr_en && wr_addr == ADDR_W'(PMASK_BASE + b / 32)) pmask[b] <= wr_data[b % 32];
        if (wr_en && wr_addr == ADDR_W'(AMASK_BASE + b / 32)) amask[b] <= wr_data[b % 32];
      end
    end
  end
endmodule

// File: rtl/tsf_counters.sv
module tsf_counters #(
  parameter int SAMPLES = 318,
  parameter int TURN_W  = 16,
  localparam int CW     = $clog2(SAMPLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              pmark,
  input  logic              amark,
  input  logic              inject,
  output logic [CW-1:0]     p_lab,
  output logic [CW-1:0]     a_lab,
  output logic [TURN_W-1:0] t_lab,
  output logic              p_last
);
  logic [CW-1:0]     pc, ac;
  logic [TURN_W-1:0] tc;
  logic              a_last;

  // marker wins over the running count, including at the wrap point
  assign p_lab  = pmark  ? '0 : pc;
  assign a_lab  = amark  ? '0 : ac;
  assign t_lab  = inject ? '0 : tc;
  assign p_last = (p_lab == CW'(SAMPLES - 1));
  assign a_last = (a_lab == CW'(SAMPLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0;
      ac <= '0;
      tc <= '0;
    end else if (adv) begin
      pc <= p_last ? '0 : p_lab + CW'(1);
      ac <= a_last ? '0 : a_lab + CW'(1);
      tc <= t_lab + TURN_W'(p_last);
    end
  end

  // R1
  psamp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pc) < SAMPLES);
  // R2
  asamp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ac) < SAMPLES);
  // R3
  turn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(tc));
endmodule

// File: rtl/tsf_trigger.sv
module tsf_trigger #(
  parameter int TURN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              window_en,
  input  logic [TURN_W-1:0] nturns,
  input  logic              start,
  input  logic              adv,
  input  logic              inject,
  input  logic              turn_end,
  output logic              capture,
  output logic              active,
  output logic              done
);
  logic [TURN_W-1:0] got, got_n;
  logic              idle_inj, inj_go, in_win, zero_n;

  assign zero_n   = (nturns == '0);
  assign idle_inj = window_en && inject && !active && !done;
  assign inj_go   = idle_inj && !zero_n;
  assign in_win   = window_en && (active || inj_go);
  assign capture  = !window_en || in_win;
  assign got_n    = (active ? got : '0) + TURN_W'(turn_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      done   <= 1'b0;
      got    <= '0;
    end else if (start) begin
      active <= !zero_n;
      done   <= zero_n;
      got    <= '0;
    end else if (adv) begin
      if (idle_inj && zero_n) begin
        done <= 1'b1;
      end else if (in_win) begin
        got <= got_n;
        if (turn_end && got_n == nturns) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          active <= 1'b1;
        end
      end
    end
  end

  // R8
  win_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(active && done));
  // R9
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !start) |=> !$rose(done));
endmodule

// File: rtl/turn_sample_filter.sv
module turn_sample_filter #(
  parameter int NLINK   = 8,
  parameter int LANE_W  = 16,
  parameter int SAMPLES = 318,
  parameter int TURN_W  = 16,
  parameter int ADDR_W  = 6,
  localparam int DW     = NLINK * LANE_W,
  localparam int CW     = $clog2(SAMPLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_flags,
  input  logic [DW-1:0]     in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic [CW-1:0]     out_psamp,
  output logic [CW-1:0]     out_asamp,
  output logic [TURN_W-1:0] out_turn,
  output logic              acq_active,
  output logic              acq_done
);
  import tsf_pkg::*;

  logic                filter_en, window_en, start;
  logic [TURN_W-1:0]   nturns;
  logic [NLINK-1:0]    link_en;
  logic [SAMPLES-1:0]  pmask, amask;
  logic                accept, inject, p_last, capture, fwd;
  logic [CW-1:0]       p_lab, a_lab;
  logic [TURN_W-1:0]   t_lab;
  logic [DW-1:0]       lanes;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign inject   = in_flags[FL_PINJ] || in_flags[FL_AINJ];

  tsf_regs #(.NLINK(NLINK), .SAMPLES(SAMPLES), .TURN_W(TURN_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .filter_en(filter_en), .window_en(window_en), .nturns(nturns), .link_en(link_en),
    .pmask(pmask), .amask(amask), .start(start));

  tsf_counters #(.SAMPLES(SAMPLES), .TURN_W(TURN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .adv(accept),
    .pmark(in_flags[FL_PMARK]), .amark(in_flags[FL_AMARK]), .inject(inject),
    .p_lab(p_lab), .a_lab(a_lab), .t_lab(t_lab), .p_last(p_last));

  tsf_trigger #(.TURN_W(TURN_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .window_en(window_en), .nturns(nturns), .start(start),
    .adv(accept), .inject(inject), .turn_end(p_last),
    .capture(capture), .active(acq_active), .done(acq_done));

  assign fwd = capture && (!filter_en || pmask[p_lab] || amask[a_lab]);

  for (genvar i = 0; i < NLINK; i++) begin : g_lane
    assign lanes[i*LANE_W +: LANE_W] = link_en[i] ? in_data[i*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_psamp <= '0;
      out_asamp <= '0;
      out_turn  <= '0;
    end else if (accept && fwd) begin
      out_valid <= 1'b1;
      out_data  <= lanes;
      out_psamp <= p_lab;
      out_asamp <= a_lab;
      out_turn  <= t_lab;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_psamp)));
  // R11
  no_take_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !accept);
endmodule

// File: tb/turn_sample_filter_tb.sv
module turn_sample_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NLINK = 8;
  localparam int LANE_W = 16;
  localparam int SAMP = 318;
  localparam int DW = NLINK * LANE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [3:0] in_flags = '0;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic [8:0] out_psamp, out_asamp;
  logic [15:0] out_turn;
  logic acq_active, acq_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  turn_sample_filter u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_flags(in_flags), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_psamp(out_psamp), .out_asamp(out_asamp), .out_turn(out_turn),
    .acq_active(acq_active), .acq_done(acq_done));

  int checks = 0;
  int errors = 0;
  string tag = "R11";

  // reference state
  int mp = 0, ma = 0, mt = 0, mgot = 0, nt = 0;
  bit mact = 0, mdone = 0, filt = 0, nten = 0;
  bit [7:0] len = 8'hFF;
  bit pm [SAMP];
  bit am [SAMP];

  typedef struct { int p; int a; int t; logic [DW-1:0] d; bit r4; } exp_t;
  exp_t q[$];
  bit prev_stall = 0;
  logic [DW-1:0] prev_data;
  bit took;
  int rdy_pct = 75;

  task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] lane_mask(logic [DW-1:0] d);
    logic [DW-1:0] r = d;
    for (int i = 0; i < NLINK; i++)
      if (!len[i]) r[i*LANE_W +: LANE_W] = '0;
    return r;
  endfunction

  task automatic model_accept(logic [3:0] fl, logic [DW-1:0] d);
    bit pmk, amk, inj, plast, cap, win, fwd;
    int p, a, t, g;
    exp_t e;
    pmk = fl[1]; amk = fl[0]; inj = fl[3] | fl[2];
    p = pmk ? 0 : mp;
    a = amk ? 0 : ma;
    t = inj ? 0 : mt;
    plast = (p == SAMP - 1);
    cap = 0; win = 0;
    if (!nten) cap = 1;
    else if (mact) begin cap = 1; win = 1; end
    else if (inj && !mdone) begin
      if (nt == 0) mdone = 1;
      else begin cap = 1; win = 1; end
    end
    if (win) begin
      g = (mact ? mgot : 0) + int'(plast);
      if (plast && g == nt) begin mact = 0; mdone = 1; end
      else mact = 1;
      mgot = g;
    end
    fwd = cap && (!filt || pm[p] || am[a]);
    if (fwd) begin
      e.p = p; e.a = a; e.t = t; e.d = lane_mask(d); e.r4 = pmk && (mp == SAMP - 1);
      q.push_back(e);
    end
    mp = plast ? 0 : p + 1;
    ma = (a == SAMP - 1) ? 0 : a + 1;
    mt = (t + int'(plast)) % 65536;
  endtask

  task automatic cycle(bit send, logic [3:0] fl, logic [DW-1:0] d);
    exp_t e;
    @(negedge clk);
    chk(acq_done === mdone, tag, "acq_done", DW'(acq_done), DW'(mdone));
    chk(acq_active === mact, tag, "acq_active", DW'(acq_active), DW'(mact));
    out_ready = ($urandom % 100) < rdy_pct;
    in_valid = send; in_flags = fl; in_data = d;
    #1;
    if (prev_stall)
      chk(out_valid === 1'b1 && out_data === prev_data, "R11", "stalled beat changed", out_data, prev_data);
    chk(in_ready === (!out_valid || out_ready), "R11", "in_ready", DW'(in_ready), DW'(!out_valid || out_ready));
    if (out_valid && out_ready) begin
      if (q.size() == 0) begin
        chk(0, tag, "unexpected forwarded beat", DW'(out_psamp), '0);
      end else begin
        e = q.pop_front();
        chk(int'(out_psamp) == e.p, e.r4 ? "R4" : "R1 R12", "proton label", DW'(out_psamp), DW'(e.p));
        chk(int'(out_asamp) == e.a, "R2 R12", "antiproton label", DW'(out_asamp), DW'(e.a));
        chk(int'(out_turn) == e.t, e.r4 ? "R4" : "R3 R12", "turn label", DW'(out_turn), DW'(e.t));
        chk(out_data === e.d, "R7", "lane data", out_data, e.d);
      end
    end
    took = send && in_ready;
    if (took) model_accept(fl, d);
    prev_stall = out_valid && !out_ready;
    prev_data = out_data;
  endtask

  task automatic send(logic [3:0] fl);
    logic [DW-1:0] d;
    d = {$urandom, $urandom, $urandom, $urandom};
    do cycle(1'b1, fl, d); while (!took);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 4'h0, '0);
  endtask

  task automatic drain;
    int guard = 0;
    while ((q.size() != 0 || out_valid) && guard < 200) begin
      cycle(1'b0, 4'h0, '0);
      guard++;
    end
    chk(q.size() == 0, tag, "beats still expected", DW'(q.size()), '0);
  endtask

  task automatic wreg(int a, logic [31:0] v);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b0;
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = v;
    #1;
    prev_stall = out_valid; prev_data = out_data;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    case (a)
      'h00: begin filt = v[0]; nten = v[1]; end
      'h01: len = v[7:0];
      'h02: nt = int'(v[15:0]);
      'h03: if (v[0]) begin mact = (nt != 0); mdone = (nt == 0); mgot = 0; end
      default: begin
        for (int j = 0; j < 32; j++) begin
          if (a >= 'h10 && a < 'h1A && (a - 'h10) * 32 + j < SAMP) pm[(a - 'h10) * 32 + j] = v[j];
          if (a >= 'h20 && a < 'h2A && (a - 'h20) * 32 + j < SAMP) am[(a - 'h20) * 32 + j] = v[j];
        end
      end
    endcase
  endtask

  function automatic logic [3:0] rnd_flags(int inj_pct);
    logic [3:0] f = '0;
    f[1] = ($urandom % 100) < 2;
    f[0] = ($urandom % 100) < 2;
    f[3] = ($urandom % 100) < inj_pct;
    f[2] = ($urandom % 100) < inj_pct;
    return f;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < SAMP; i++) begin pm[i] = 0; am[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk(out_valid === 1'b0, "R11", "out_valid after reset", DW'(out_valid), '0);
    chk(acq_done === 1'b0 && acq_active === 1'b0, "R11", "window flags after reset", DW'({acq_done, acq_active}), '0);
    chk(in_ready === 1'b1, "R11", "in_ready after reset", DW'(in_ready), 1);

    // R6 R10: everything forwarded; R4 directed collision
    tag = "R6 R10";
    send(4'b0010);
    for (int i = 0; i < SAMP - 2; i++) send(4'b0000);
    send(4'b0010);                       // R4: marker where label would be 317
    for (int i = 0; i < 2 * SAMP + 5; i++) send(4'b0000);  // natural wraps, R3 turn steps
    for (int i = 0; i < 300; i++) send(rnd_flags(1));
    drain();

    // R5 R7: masks and link enables
    tag = "R5";
    for (int k = 0; k < 10; k++) begin
      wreg('h10 + k, $urandom & $urandom);
      wreg('h20 + k, $urandom & $urandom);
    end
    wreg('h01, 32'(8'($urandom)));
    wreg('h00, 32'h1);
    for (int i = 0; i < 700; i++) send(rnd_flags(1));
    drain();
    wreg('h01, 32'hFF);

    // R8: window from injection
    tag = "R8";
    wreg('h00, 32'h2);
    wreg('h02, 32'd2);
    for (int i = 0; i < 40; i++) send(4'b0000);
    send(4'b1000);
    for (int i = 0; i < 2 * SAMP + 60; i++) send(4'b0000);
    drain();
    chk(acq_done === 1'b1 && acq_active === 1'b0, "R8", "done after N turns", DW'({acq_done, acq_active}), 2);
    send(4'b0100);
    for (int i = 0; i < 20; i++) send(4'b0000);
    drain();

    // R9: software start
    tag = "R9";
    wreg('h02, 32'd1);
    wreg('h03, 32'h1);
    chk(acq_done === 1'b0 && acq_active === 1'b1, "R9", "start opens window", DW'({acq_done, acq_active}), 1);
    for (int i = 0; i < SAMP + 40; i++) send(rnd_flags(0));
    drain();
    wreg('h02, 32'd0);
    wreg('h03, 32'h1);
    chk(acq_done === 1'b1 && acq_active === 1'b0, "R9", "start with N=0", DW'({acq_done, acq_active}), 2);
    for (int i = 0; i < 20; i++) send(4'b1000);
    drain();
    idle(3);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule